// File: doc/BRIEF.md
# Write-Once Flash Tick Divider

This block holds the timing setup for a nonvolatile-memory controller and turns the bus clock into a slow timing tick. An 8-bit control register holds a divisor N in its low six bits and a prescaler select in bit 6. The register takes only the first write after reset. That write also sets a read-only "configured" flag in bit 7, whatever data it carries. The flag releases the erase and program enable and starts the divider.

The tick is a single-bus-cycle enable pulse, not a derived clock, so the whole design stays in the bus clock domain. With the prescaler off, a tick comes every N+1 bus cycles. With it on, the bus rate is first divided by 8, so a tick comes every 8×(N+1) cycles. One tick period is the basic program/erase time unit. A downstream sequencer counts an integer number of these periods to time each operation. Until the flag is set, both counters are held cleared and no tick is produced.

Top module: `flash_tick_divider`

## Requirements
- R1: While `rst_ni` is low, all eight register bits are cleared. A read returns 0x00, `loaded_o` is 0 and `tick_o` is 0.
- R2: The first write after reset stores `wdata_i[6]` as the prescaler select and `wdata_i[5:0]` as the divisor N. The value of `wdata_i[7]` is ignored.
- R3: Every write after the first leaves bits 6..0 unchanged, so the readback value and the tick spacing stay the same.
- R4: The first write after reset sets `loaded_o` to 1 even when the written data is 0x00. It then stays 1 until the next reset.
- R5: `pe_en_o` is 0 before the first write and 1 from the cycle after it.
- R6: No tick is produced while `loaded_o` is 0.
- R7: With the prescaler select at 0, `tick_o` is high in the cycles numbered k·(N+1), counting from 1 at the cycle after the loading write. With N = 0, it is high in every such cycle.
- R8: With the prescaler select at 1, `tick_o` is high in the cycles numbered k·8·(N+1), counted the same way.
- R9: Unless N = 0 and the prescaler is off, `tick_o` is never high in two consecutive cycles.
- R10: When `rd_en_i` is high, `rdata_o` shows {flag, prescaler select, N} in the same cycle. When `rd_en_i` is low, `rdata_o` is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data: {flag, prescaler select, N}, or zero when not reading |
| tick_o | output | 1 | One-cycle timing tick at the divided rate |
| loaded_o | output | 1 | Configured flag (register has been written) |
| pe_en_o | output | 1 | Erase/program enable |

## Verification
The assertions assume that `rst_ni` is released with a defined value on every other input. They also assume the write strobe is a clean level sampled on the rising edge, so the first sampled strobe is the one that loads. The stimulus changes inputs only just after a rising edge and holds each strobe for exactly one cycle. It asserts reset between configurations, so every test starts from the unloaded state. Repeated writes with different data are issued on purpose after loading, to show that they are ignored.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;
  localparam int unsigned DIV_W_DEF = 6;
  localparam int unsigned PRE_RATIO_DEF = 8;

  typedef enum logic {
    PRE_BYPASS = 1'b0,
    PRE_DIVIDE = 1'b1
  } pre_mode_e;
endpackage

// File: rtl/fdiv_ctrl_reg.sv
module fdiv_ctrl_reg #(
  parameter int unsigned DIV_W = fdiv_pkg::DIV_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             pre_wr_i,
  input  logic [DIV_W-1:0] div_wr_i,
  output logic             loaded_o,
  output fdiv_pkg::pre_mode_e pre_mode_o,
  output logic [DIV_W-1:0] div_o
);
  import fdiv_pkg::*;

  logic             loaded_q;
  pre_mode_e        pre_q;
  logic [DIV_W-1:0] div_q;

  // only the first write lands; the flag sets regardless of data
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      loaded_q <= 1'b0;
      pre_q    <= PRE_BYPASS;
      div_q    <= '0;
    end else if (wr_en_i && !loaded_q) begin
      loaded_q <= 1'b1;
      pre_q    <= pre_mode_e'(pre_wr_i);
      div_q    <= div_wr_i;
    end
  end

  assign loaded_o   = loaded_q;
  assign pre_mode_o = pre_q;
  assign div_o      = div_q;

  p_hold_after_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loaded_q |=> ($stable(div_q) && $stable(pre_q)));
  p_flag_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loaded_q |=> loaded_q);
  p_flag_on_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> loaded_q);
endmodule

// File: rtl/fdiv_prescale.sv
module fdiv_prescale #(
  parameter int unsigned RATIO = fdiv_pkg::PRE_RATIO_DEF
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  fdiv_pkg::pre_mode_e mode_i,
  output logic                step_o
);
  import fdiv_pkg::*;

  generate
    if (RATIO > 1) begin : g_div
      localparam int unsigned CW = $clog2(RATIO);
      localparam logic [CW-1:0] LAST = CW'(RATIO - 1);
      logic [CW-1:0] cnt_q;
      logic          run;

      assign run = en_i && (mode_i == PRE_DIVIDE);

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)            cnt_q <= '0;
        else if (!run)          cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
      end

      assign step_o = run ? (cnt_q == LAST) : en_i;

      p_wrap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run && cnt_q == LAST) |=> (cnt_q == '0));
    end else begin : g_pass
      logic unused_mode;
      assign unused_mode = mode_i;
      assign step_o = en_i;
    end
  endgenerate
endmodule

// File: rtl/fdiv_counter.sv
module fdiv_counter #(
  parameter int unsigned DIV_W = fdiv_pkg::DIV_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             step_i,
  input  logic [DIV_W-1:0] limit_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             at_end;

  assign at_end = (cnt_q == limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (step_i) cnt_q <= at_end ? '0 : cnt_q + 1'b1;
  end

  assign tick_o = run_i && step_i && at_end;

  p_cnt_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q <= limit_i));
endmodule

// File: rtl/flash_tick_divider.sv
module flash_tick_divider #(
  parameter int unsigned DIV_W     = fdiv_pkg::DIV_W_DEF,
  parameter int unsigned PRE_RATIO = fdiv_pkg::PRE_RATIO_DEF,
  localparam int unsigned DATA_W   = DIV_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              tick_o,
  output logic              loaded_o,
  output logic              pe_en_o
);
  import fdiv_pkg::*;

  logic             loaded;
  pre_mode_e        pre_mode;
  logic [DIV_W-1:0] div;
  logic             step;
  logic             unused_wflag;

  assign unused_wflag = wdata_i[DATA_W-1];

  fdiv_ctrl_reg #(.DIV_W(DIV_W)) u_reg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .pre_wr_i   (wdata_i[DIV_W]),
    .div_wr_i   (wdata_i[DIV_W-1:0]),
    .loaded_o   (loaded),
    .pre_mode_o (pre_mode),
    .div_o      (div)
  );

  fdiv_prescale #(.RATIO(PRE_RATIO)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (loaded),
    .mode_i (pre_mode),
    .step_o (step)
  );

  fdiv_counter #(.DIV_W(DIV_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (loaded),
    .step_i  (step),
    .limit_i (div),
    .tick_o  (tick_o)
  );

  assign rdata_o  = rd_en_i ? {loaded, pre_mode, div} : '0;
  assign loaded_o = loaded;
  assign pe_en_o  = loaded;

  p_no_tick_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !loaded |-> !tick_o);
  p_tick_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && (pre_mode == PRE_DIVIDE || div != '0)) |=> !tick_o);
  p_pe_after_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pe_en_o) |-> $past(wr_en_i));
endmodule

// File: tb/sim_flash_tick_divider.sv
module sim_flash_tick_divider;
  localparam int RATIO = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       tick, loaded, pe_en;

  int n_cmp = 0;
  int n_bad = 0;
  bit cmp_on = 1'b0;

  flash_tick_divider u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .wdata_i(wdata), .rdata_o(rdata), .tick_o(tick),
    .loaded_o(loaded), .pe_en_o(pe_en)
  );

  always #2 clk = ~clk;

  // behavioural reference: cycle index since loading
  bit       m_loaded;
  bit       m_pre;
  bit [5:0] m_div;
  int       m_k;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_loaded = 0; m_pre = 0; m_div = 0; m_k = 0;
    end else if (m_loaded) begin
      m_k++;
    end else if (wr_en) begin
      m_loaded = 1; m_pre = wdata[6]; m_div = wdata[5:0]; m_k = 1;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      int per;
      bit exp_tick;
      string tag;
      per = (m_pre ? RATIO : 1) * (int'(m_div) + 1);
      exp_tick = m_loaded && (m_k % per == 0);
      tag = !m_loaded ? "R6" : (m_pre ? "R8" : "R7");
      chk(tag, "tick", tick, exp_tick);
      chk("R4", "loaded", loaded, m_loaded);
      chk("R5", "pe_en", pe_en, m_loaded);
      chk("R10", "rdata", rdata, rd_en ? {m_loaded, m_pre, m_div} : 0);
      if (tick && (m_pre || m_div != 0)) begin
        @(posedge clk);
        #1 chk("R9", "tick repeat", tick, 0);
      end
    end
  end

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cyc(2);
    @(negedge clk);
    chk("R1", "rdata in reset", rdata, 0);
    chk("R1", "loaded in reset", loaded, 0);
    chk("R1", "tick in reset", tick, 0);
    cyc(1);
    rst_n = 1'b1;
    cyc(1);
  endtask

  task automatic do_write(logic [7:0] d);
    wr_en = 1'b1;
    wdata = d;
    cyc(1);
    wr_en = 1'b0;
    wdata = 8'h00;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rd_en = 1'b1;
    cyc(2);
    cmp_on = 1'b1;
    do_reset();
    cyc(20);                         // R6: idle, no ticks

    do_write(8'h00);                 // R4: zero data still sets flag
    @(negedge clk);
    chk("R4", "readback after zero write", rdata, 8'h80);
    cyc(10);                         // R7: N=0 ticks every cycle
    do_write(8'h45);                 // R3: ignored
    @(negedge clk);
    chk("R3", "readback after second write", rdata, 8'h80);
    cyc(12);

    do_reset();
    do_write(8'h83);                 // R2: bit7 of data dropped, N=3
    @(negedge clk);
    chk("R2", "fields", rdata, 8'h83);
    cyc(40);

    do_reset();
    do_write(8'h42);                 // R8: period 24
    @(negedge clk);
    chk("R2", "prescale field", rdata, 8'hC2);
    cyc(100);

    do_reset();
    do_write(8'h40);                 // R8: period 8
    cyc(30);
    do_write(8'h05);                 // R3: ignored, spacing unchanged
    cyc(40);
    rd_en = 1'b0;
    cyc(3);
    @(negedge clk);
    chk("R10", "rdata without read", rdata, 8'h00);
    rd_en = 1'b1;

    do_reset();
    do_write(8'h3F);                 // R7: period 64
    cyc(200);
    do_write(8'hFF);                 // R3
    cyc(80);

    do_reset();                      // R1: reset after loading
    cyc(5);
    cmp_on = 1'b0;
    summary();
  end
endmodule